// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences the low-power sleep states of a small microcontroller core. When the processor raises a one-cycle sleep strobe, the block reads four system-control bits and decides whether to nap. The nap can be at full speed or at reduced speed. A sleep strobe carrying any other control-bit pattern is dropped. While napping, the block withdraws the CPU clock enable and leaves the peripheral clock running. Processor state is kept because the core is simply not clocked.

The block watches a 32-bit interrupt request vector, a matching per-source enable vector and a global interrupt mask. A request that is enabled and unmasked passes through a two-flop synchroniser. It then wakes the core into the active mode that matches the nap it came from, and raises a one-cycle wake pulse that starts exception handling. An active-low reset returns the block to full-speed active at any time. The reset does not depend on the mask.

The peripheral clock divider select gives the divide ratio as a power of two. It is 0 (undivided) in the full-speed modes. In the reduced-speed modes it follows a two-bit rate field.

Top module: `slp_pwr_ctl`

## Requirements
- R1: While rst_n is low, mode is 2'b00 (full-speed active), cpu_clk_en is 1, wake_pulse is 0 and div_log2 is 0.
- R2: In an active mode, a sleep_req sampled with cfg_standby=0, cfg_lowspd=0, cfg_medspd=0 and cfg_direct=0 sets mode to 2'b10 (full-speed sleep) after that clock edge, and drops cpu_clk_en in the same cycle.
- R3: In an active mode, a sleep_req sampled with cfg_medspd=1 and the other three control bits at 0 sets mode to 2'b11 (reduced-speed sleep), and drops cpu_clk_en.
- R4: A sleep_req with cfg_standby, cfg_lowspd or cfg_direct set leaves the mode unchanged. Any sleep_req that arrives while in a sleep mode also leaves the mode unchanged.
- R5: div_log2 is 0 in modes 2'b00 and 2'b10. In modes 2'b01 and 2'b11 it is 3 + rate_sel, so rate_sel 00, 01, 10 and 11 divide by 8, 16, 32 and 64.
- R6: A wake from mode 2'b10 enters 2'b00, and a wake from mode 2'b11 enters 2'b01 (reduced-speed active).
- R7: A wake needs at least one bit i with irq_req[i]=1 and irq_en[i]=1 while irq_mask=0. Otherwise the block stays asleep.
- R8: A qualifying request first sampled at clock edge k, and held, changes the mode at edge k+2.
- R9: wake_pulse is high for exactly one cycle, the first active cycle after a sleep mode. cpu_clk_en is 1 in that same cycle.
- R10: Driving rst_n low while asleep returns mode to 2'b00 with cpu_clk_en 1, even with irq_mask=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| cfg_standby | input | 1 | Standby select control bit (must be 0 to nap) |
| cfg_lowspd | input | 1 | Low-speed select control bit (must be 0 to nap) |
| cfg_medspd | input | 1 | Selects reduced-speed sleep |
| cfg_direct | input | 1 | Direct-transfer control bit (must be 0 to nap) |
| rate_sel | input | 2 | Reduced-speed divide field |
| irq_req | input | 32 | Interrupt request vector |
| irq_en | input | 32 | Per-source interrupt enable vector |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks all wakes |
| mode | output | 2 | Current mode: 00 full active, 01 reduced active, 10 full sleep, 11 reduced sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| div_log2 | output | 3 | log2 of the peripheral/system clock divide ratio |
| wake_pulse | output | 1 | One-cycle start of exception handling |

## Verification
Sleep entry is tried with the valid full-speed and reduced-speed patterns, and with each blocking control bit set on its own. This separates the decode from a bare strobe check. Wakes are offered with the global mask set, with a request whose enable bit is clear, and with a request on a different bit that is enabled. This separates the AND-then-OR qualification from either input alone. Holding a request and counting edges until the mode changes pins the two-cycle synchroniser latency. A reset pulse while asleep with the mask set shows that reset does not depend on the interrupt logic.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    PM_RUN_FULL = 2'b00,
    PM_RUN_MED  = 2'b01,
    PM_NAP_FULL = 2'b10,
    PM_NAP_MED  = 2'b11
  } pmode_t;

  localparam int DIV_W = 3;

  typedef struct packed {
    logic   ok;
    pmode_t target;
  } entry_t;

  // Which nap a sleep strobe selects; ok=0 means the strobe is dropped
  function automatic entry_t decode_entry(input logic standby, input logic lowspd,
                                         input logic medspd, input logic direct);
    entry_t e;
    e.ok     = !standby && !lowspd && !direct;
    e.target = medspd ? PM_NAP_MED : PM_NAP_FULL;
    return e;
  endfunction

  // Active mode reached when waking from a given nap
  function automatic pmode_t wake_target(input pmode_t m);
    return (m == PM_NAP_MED) ? PM_RUN_MED : PM_RUN_FULL;
  endfunction

  // Reduced-speed divide as a power of two: 8 << rate
  function automatic logic [DIV_W-1:0] rate_log2(input logic [1:0] rate);
    return DIV_W'(3) + DIV_W'(rate);
  endfunction

  function automatic logic is_napping(input pmode_t m);
    return m[1];
  endfunction

endpackage

// File: rtl/slp_irq_qual.sv
module slp_irq_qual #(
  parameter int N_SRC       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             irq_mask,
  output logic             qual_any,
  output logic             wake_req
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;

  assign qual_any = (|(irq_req & irq_en)) && !irq_mask;

  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= qual_any;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign wake_req = sync_q[LAST];

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(qual_any, 2)); // R8
    end
  endgenerate

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !sync_q[0]); // R7

endmodule

// File: rtl/slp_mode_fsm.sv
module slp_mode_fsm
  import slp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sleep_req,
  input  logic   cfg_standby,
  input  logic   cfg_lowspd,
  input  logic   cfg_medspd,
  input  logic   cfg_direct,
  input  logic   wake_req,
  output pmode_t mode_q,
  output logic   wake_pulse,
  output logic   enter_evt,
  output logic   wake_evt
);

  entry_t ent;
  logic   asleep;

  assign ent       = decode_entry(cfg_standby, cfg_lowspd, cfg_medspd, cfg_direct);
  assign asleep    = is_napping(mode_q);
  assign wake_evt  = asleep && wake_req;
  assign enter_evt = !asleep && sleep_req && ent.ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PM_RUN_FULL;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= wake_evt;
      if (wake_evt)       mode_q <= wake_target(mode_q);
      else if (enter_evt) mode_q <= ent.target;
    end
  end

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R9

  AST_WAKE_LEAVES_NAP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!mode_q[1] && $past(mode_q[1]))); // R6

  AST_MED_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && $past(mode_q) == PM_NAP_MED) |-> mode_q == PM_RUN_MED); // R6

  AST_NAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !wake_req) |=> mode_q == $past(mode_q)); // R4

endmodule

// File: rtl/slp_clk_ctl.sv
module slp_clk_ctl
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pmode_t           mode_q,
  input  logic [1:0]       rate_sel,
  input  logic             sleep_req,
  output logic             cpu_clk_en,
  output logic [DIV_W-1:0] div_log2
);

  logic med_rate;

  assign med_rate   = (mode_q == PM_RUN_MED) || (mode_q == PM_NAP_MED);
  assign cpu_clk_en = !is_napping(mode_q);
  assign div_log2   = med_rate ? rate_log2(rate_sel) : '0;

  AST_CLK_STOPS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(sleep_req)); // R2

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_log2 == '0) || (div_log2 >= DIV_W'(3) && div_log2 <= DIV_W'(6))); // R5

endmodule

// File: rtl/slp_pwr_ctl.sv
module slp_pwr_ctl
  import slp_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             cfg_standby,
  input  logic             cfg_lowspd,
  input  logic             cfg_medspd,
  input  logic             cfg_direct,
  input  logic [1:0]       rate_sel,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             irq_mask,
  output logic [1:0]       mode,
  output logic             cpu_clk_en,
  output logic [2:0]       div_log2,
  output logic             wake_pulse
);

  pmode_t mode_q;
  logic   qual_any;
  logic   wake_req;
  logic   enter_evt;
  logic   wake_evt;

  slp_irq_qual #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .irq_mask (irq_mask),
    .qual_any (qual_any),
    .wake_req (wake_req)
  );

  slp_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .cfg_standby (cfg_standby),
    .cfg_lowspd  (cfg_lowspd),
    .cfg_medspd  (cfg_medspd),
    .cfg_direct  (cfg_direct),
    .wake_req    (wake_req),
    .mode_q      (mode_q),
    .wake_pulse  (wake_pulse),
    .enter_evt   (enter_evt),
    .wake_evt    (wake_evt)
  );

  slp_clk_ctl u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .rate_sel   (rate_sel),
    .sleep_req  (sleep_req),
    .cpu_clk_en (cpu_clk_en),
    .div_log2   (div_log2)
  );

  assign mode = mode_q;

  AST_ENTER_WAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_evt && wake_evt)); // R4

  AST_ENTER_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> mode_q[1]); // R3

endmodule

// File: tb/slp_pwr_ctl_test.sv
module slp_pwr_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic        sb = 1'b0, ls = 1'b0, md = 1'b0, dt = 1'b0;
  logic [1:0]  rate = 2'b00;
  logic [31:0] req = '0, en = '0;
  logic        mask = 1'b1;
  logic [1:0]  mode;
  logic        cpu_en, wake;
  logic [2:0]  div;

  int    vectors = 0, misses = 0;
  string cur = "R1";
  bit    done = 0;

  slp_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .cfg_standby(sb), .cfg_lowspd(ls), .cfg_medspd(md), .cfg_direct(dt),
    .rate_sel(rate), .irq_req(req), .irq_en(en), .irq_mask(mask),
    .mode(mode), .cpu_clk_en(cpu_en), .div_log2(div), .wake_pulse(wake)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: integer mode plus a history queue of qualified requests
  int m_mode = 0;
  bit m_wake = 0;
  bit hist[$] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_wake = 0; hist = '{0, 0};
    end else begin
      bit q;
      q = ((req & en) != 0) && !mask;
      m_wake = 0;
      if (m_mode >= 2 && hist[1]) begin
        m_mode = (m_mode == 3) ? 1 : 0;
        m_wake = 1;
      end else if (m_mode < 2 && sleep_req && !sb && !ls && !dt) begin
        m_mode = md ? 3 : 2;
      end
      hist.push_front(q);
      void'(hist.pop_back());
    end
  end

  function automatic int exp_div();
    return (m_mode == 1 || m_mode == 3) ? 3 + int'(rate) : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(cur, int'(mode), m_mode, "mode");
    check(cur, int'(cpu_en), (m_mode < 2) ? 1 : 0, "cpu_clk_en");
    check(cur, int'(div), exp_div(), "div_log2");
    check(cur, int'(wake), int'(m_wake), "wake_pulse");
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic nap(input logic s, input logic l, input logic m, input logic d);
    sb = s; ls = l; md = m; dt = d; sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0; sb = 0; ls = 0; md = 0; dt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur = "R1";
    cyc(1);
    check("R1", int'(mode), 0, "reset mode");
    check("R1", int'(cpu_en), 1, "reset clk en");
    check("R1", int'(wake), 0, "reset wake");
    rst_n = 1'b1;
    cyc(2);

    cur = "R2";
    nap(0, 0, 0, 0);
    check("R2", int'(mode), 2, "full nap entered");
    check("R2", int'(cpu_en), 0, "clk stopped");

    cur = "R7";
    mask = 1'b1; req = 32'h0000_0010; en = 32'h0000_0010;
    cyc(5);
    check("R7", int'(mode), 2, "masked irq holds nap");
    mask = 1'b0; req = 32'h0000_0100; en = 32'h0000_0010;
    cyc(5);
    check("R7", int'(mode), 2, "disabled source holds nap");

    cur = "R8";
    en = 32'h0000_0110;
    cyc(2);
    check("R8", int'(mode), 2, "still asleep after two edges");
    cyc(1);
    check("R8", int'(mode), 0, "awake at third edge");
    cur = "R9";
    check("R9", int'(wake), 1, "wake pulse high");
    check("R9", int'(cpu_en), 1, "clk en with pulse");
    cyc(1);
    check("R9", int'(wake), 0, "wake pulse single");
    req = '0; mask = 1'b1;
    cyc(3);

    cur = "R3";
    rate = 2'b10;
    nap(0, 0, 1, 0);
    check("R3", int'(mode), 3, "reduced nap entered");
    cur = "R5";
    check("R5", int'(div), 5, "div for rate 10");
    for (int r = 0; r < 4; r++) begin
      rate = 2'(r);
      cyc(1);
      check("R5", int'(div), 3 + r, "div sweep");
    end

    cur = "R4";
    nap(0, 0, 0, 0);
    check("R4", int'(mode), 3, "strobe while asleep ignored");

    cur = "R6";
    mask = 1'b0; req = 32'h8000_0000; en = 32'h8000_0000;
    cyc(4);
    check("R6", int'(mode), 1, "reduced wake target");
    req = '0; mask = 1'b1;
    cyc(2);

    cur = "R4";
    nap(1, 0, 0, 0);
    check("R4", int'(mode), 1, "standby bit blocks");
    nap(0, 1, 0, 0);
    check("R4", int'(mode), 1, "low-speed bit blocks");
    nap(0, 0, 1, 1);
    check("R4", int'(mode), 1, "direct bit blocks");

    cur = "R2";
    nap(0, 0, 0, 0);
    check("R2", int'(mode), 2, "full nap from reduced active");
    cur = "R5";
    check("R5", int'(div), 0, "full nap undivided");

    cur = "R10";
    mask = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R10", int'(mode), 0, "reset clears nap");
    check("R10", int'(cpu_en), 1, "reset clk en");
    cyc(2);
    rst_n = 1'b1;
    cyc(3);

    finish_run();
  end

endmodule